// File: doc/BRIEF.md
# Multichannel ADC Channel Sequencer

This block is the digital control logic that chooses which of sixteen analog inputs a converter samples on each conversion frame. Each frame the host shifts one 16-bit word into the block, most significant bit first, on falling edges of a serial clock while an active-low frame strobe is held low. The block treats that word in one of three ways. It can be a control write. It can be a load of a 16-bit channel-enable mask. Or it can be a transfer that changes no setting and only lets a running sequence step on. From this it drives the 4-bit address of the channel to convert next.

Three operating modes are selected by two bits of the control word. The first is direct addressing: the host names every channel itself. The second walks an arbitrary channel mask in ascending order. The third walks channels 0 up to a named top channel. While a sequence runs, a control write with the keep-sequence code changes the power, range and coding settings without restarting the sequence. The serial clock, frame strobe and data input are sampled on the system clock, so their edges are found by comparing against registered copies.

Top module: `chseq_top`

## Requirements
- R1: After reset the selected channel is 0, no sequence is active, the empty-mask flag is low, no mask load is pending, and the power, range and coding outputs are 0.
- R2: A word of sixteen bits is taken MSB first. Bit 15 is the write flag, bit 14 the sequence bit, bits 13:10 the channel address, bits 9:8 power, bit 7 the shadow bit, bit 5 range and bit 4 coding. Bits 6 and 3:0 are ignored. A write with sequence=0 and shadow=0 selects the address field as the next channel and leaves no sequence active.
- R3: Every control write (write flag 1) that is not a mask-load frame copies the power, range and coding fields to their outputs. A word with the write flag at 0 leaves them unchanged.
- R4: A write with sequence=0 and shadow=1 selects the address field and ends any sequence. The next complete word is then stored as the channel mask whatever its contents are. The first received bit enables channel 0 and the last bit enables channel 15. The block then starts a sequence on the lowest enabled channel.
- R5: While a sequence runs, each complete word with the write flag at 0 moves the channel to the next enabled channel above it. After the highest enabled channel it wraps to the lowest. Enabled channels need not be adjacent.
- R6: A write with sequence=1 and shadow=1 starts a sequence over channels 0 up to and including the address field. The first channel selected is 0.
- R7: A write with sequence=1 and shadow=0 updates the settings. If a sequence is running it advances as in R5. Otherwise the channel is unchanged.
- R8: Any write whose sequence/shadow code is not sequence=1, shadow=0 ends a running sequence. Code 00 returns the block to direct addressing.
- R9: If the frame strobe rises before sixteen falling edges have been seen, the partial word is discarded and no output changes.
- R10: If the mask is loaded as all zeros, the channel stays where it was, a sequence is marked active and the empty-mask flag rises. Later words with the write flag at 0 keep the channel where it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, data taken on its falling edge |
| fs_n | input | 1 | Active-low frame strobe |
| sdi | input | 1 | Serial data in, MSB first |
| chan_sel | output | 4 | Channel to convert next |
| seq_active | output | 1 | A channel sequence is running |
| mask_empty | output | 1 | Loaded mask was all zeros |
| pwr_mode | output | 2 | Stored power-mode field |
| range_sel | output | 1 | Stored range bit |
| coding_sel | output | 1 | Stored coding bit |

## Verification
The assertions assume that sclk, fs_n and sdi change only between system clock edges. They also assume that each serial clock level lasts at least one system clock, so that every falling edge is seen exactly once. The bench drives all three inputs on the falling system clock edge and holds each serial clock level for two cycles. It holds sdi steady across each falling edge. Its random frames pick among the four write codes, zero-write frames, mask loads (some of them all zeros) and truncated frames. These are compared against a bench model of the mode rules.

// File: rtl/chseq_pkg.sv
package chseq_pkg;

    localparam int NCH    = 16;
    localparam int CH_W   = $clog2(NCH);
    localparam int WORD_W = 16;
    localparam int CNT_W  = $clog2(WORD_W + 1);

    // Field positions of the control word (MSB received first)
    localparam int F_WR    = 15;
    localparam int F_SEQ   = 14;
    localparam int F_ADDR  = 10;
    localparam int F_PWR   = 8;
    localparam int F_SHDW  = 7;
    localparam int F_RNG   = 5;
    localparam int F_COD   = 4;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [NCH-1:0]    mask_t;
    typedef logic [CH_W-1:0]   chan_t;

    typedef struct packed {
        logic [1:0] pwr;
        logic       rng;
        logic       cod;
    } settings_t;

    typedef enum logic [1:0] {
        CODE_DIRECT = 2'b00,
        CODE_ARM    = 2'b01,
        CODE_KEEP   = 2'b10,
        CODE_RANGE  = 2'b11
    } mode_code_e;

    // First-received bit (word MSB) enables channel 0
    function automatic mask_t word_to_mask(word_t w);
        mask_t m;
        for (int i = 0; i < NCH; i++) m[i] = w[WORD_W-1-i];
        return m;
    endfunction

    // Channels 0..top enabled
    function automatic mask_t range_mask(chan_t top);
        mask_t m;
        for (int i = 0; i < NCH; i++) m[i] = (i <= int'(top));
        return m;
    endfunction

    // Next enabled channel strictly after cur, wrapping; stays if mask empty
    function automatic chan_t next_chan(chan_t cur, mask_t m);
        chan_t res;
        logic  found;
        res   = cur;
        found = 1'b0;
        for (int i = 1; i <= NCH; i++) begin
            if (!found && m[(int'(cur) + i) % NCH]) begin
                res   = chan_t'((int'(cur) + i) % NCH);
                found = 1'b1;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/chseq_shift_in.sv
module chseq_shift_in
    import chseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk,
    input  logic             fs_n,
    input  logic             sdi,
    output logic             word_vld,
    output word_t            word,
    output logic [CNT_W-1:0] bit_cnt
);
    logic  sclk_q;
    logic  fall;
    word_t shreg;

    assign fall = sclk_q & ~sclk & ~fs_n;
    assign word = shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q   <= 1'b0;
            shreg    <= '0;
            bit_cnt  <= '0;
            word_vld <= 1'b0;
        end else begin
            sclk_q   <= sclk;
            word_vld <= 1'b0;
            if (fs_n) begin
                bit_cnt <= '0;
            end else if (fall && (bit_cnt < CNT_W'(WORD_W))) begin
                shreg   <= {shreg[WORD_W-2:0], sdi};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CNT_W'(WORD_W - 1)) word_vld <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/chseq_core.sv
module chseq_core
    import chseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      word_vld,
    input  word_t     word,
    output chan_t     chan,
    output logic      seq_on,
    output logic      empty,
    output logic      pend,
    output settings_t cfg
);
    mask_t      mask;
    mode_code_e code;
    chan_t      addr;
    mask_t      new_mask;

    assign code     = mode_code_e'({word[F_SEQ], word[F_SHDW]});
    assign addr     = word[F_ADDR +: CH_W];
    assign new_mask = word_to_mask(word);

    always_ff @(posedge clk) begin
        if (rst) begin
            chan   <= '0;
            seq_on <= 1'b0;
            empty  <= 1'b0;
            pend   <= 1'b0;
            mask   <= '0;
            cfg    <= '0;
        end else if (word_vld) begin
            if (pend) begin
                pend   <= 1'b0;
                mask   <= new_mask;
                seq_on <= 1'b1;
                empty  <= (new_mask == '0);
                if (new_mask != '0) chan <= next_chan(chan_t'(NCH - 1), new_mask);
            end else if (!word[F_WR]) begin
                if (seq_on) chan <= next_chan(chan, mask);
            end else begin
                cfg <= '{pwr: word[F_PWR +: 2], rng: word[F_RNG], cod: word[F_COD]};
                unique case (code)
                    CODE_DIRECT: begin
                        chan   <= addr;
                        seq_on <= 1'b0;
                        empty  <= 1'b0;
                    end
                    CODE_ARM: begin
                        chan   <= addr;
                        seq_on <= 1'b0;
                        empty  <= 1'b0;
                        pend   <= 1'b1;
                    end
                    CODE_RANGE: begin
                        mask   <= range_mask(addr);
                        chan   <= '0;
                        seq_on <= 1'b1;
                        empty  <= 1'b0;
                    end
                    CODE_KEEP: begin
                        if (seq_on) chan <= next_chan(chan, mask);
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/chseq_top.sv
module chseq_top
    import chseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sclk,
    input  logic        fs_n,
    input  logic        sdi,
    output logic [3:0]  chan_sel,
    output logic        seq_active,
    output logic        mask_empty,
    output logic [1:0]  pwr_mode,
    output logic        range_sel,
    output logic        coding_sel
);
    logic             word_vld;
    word_t            word;
    logic [CNT_W-1:0] bit_cnt;
    chan_t            chan;
    logic             pend;
    settings_t        cfg;

    chseq_shift_in u_shift (
        .clk      (clk),
        .rst      (rst),
        .sclk     (sclk),
        .fs_n     (fs_n),
        .sdi      (sdi),
        .word_vld (word_vld),
        .word     (word),
        .bit_cnt  (bit_cnt)
    );

    chseq_core u_core (
        .clk      (clk),
        .rst      (rst),
        .word_vld (word_vld),
        .word     (word),
        .chan     (chan),
        .seq_on   (seq_active),
        .empty    (mask_empty),
        .pend     (pend),
        .cfg      (cfg)
    );

    assign chan_sel   = chan;
    assign pwr_mode   = cfg.pwr;
    assign range_sel  = cfg.rng;
    assign coding_sel = cfg.cod;
endmodule

// File: rtl/chseq_checker.sv
module chseq_checker
    import chseq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             word_vld,
    input word_t            word,
    input logic [CNT_W-1:0] bit_cnt,
    input logic             pend,
    input logic [3:0]       chan_sel,
    input logic             seq_active,
    input logic             mask_empty
);
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (chan_sel == 4'd0 && !seq_active && !mask_empty && !pend));

    a_r2_direct_select: assert property (@(posedge clk) disable iff (rst)
        (word_vld && !pend && word[15] && !word[14] && !word[7])
        |=> (chan_sel == $past(word[13:10]) && !seq_active));

    a_r6_range_start: assert property (@(posedge clk) disable iff (rst)
        (word_vld && !pend && word[15] && word[14] && word[7])
        |=> (chan_sel == 4'd0 && seq_active));

    a_r9_chan_held: assert property (@(posedge clk) disable iff (rst)
        !$past(word_vld) |-> $stable(chan_sel));

    a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= CNT_W'(WORD_W));

    a_r10_empty_in_seq: assert property (@(posedge clk) disable iff (rst)
        mask_empty |-> seq_active);
endmodule

bind chseq_top chseq_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .word_vld   (word_vld),
    .word       (word),
    .bit_cnt    (bit_cnt),
    .pend       (pend),
    .chan_sel   (chan_sel),
    .seq_active (seq_active),
    .mask_empty (mask_empty)
);

// File: tb/chseq_top_bench.sv
module chseq_top_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0;
    logic fs_n = 1'b1;
    logic sdi = 1'b0;
    logic [3:0] chan_sel;
    logic seq_active, mask_empty, range_sel, coding_sel;
    logic [1:0] pwr_mode;

    int checks = 0;
    int errors = 0;

    // Bench model state
    logic [3:0]  m_chan;
    logic        m_seq, m_empty, m_pend;
    logic [15:0] m_mask;
    logic [1:0]  m_pwr;
    logic        m_rng, m_cod;

    always #5 clk = ~clk;

    chseq_top u_chseq_top (
        .clk(clk), .rst(rst), .sclk(sclk), .fs_n(fs_n), .sdi(sdi),
        .chan_sel(chan_sel), .seq_active(seq_active), .mask_empty(mask_empty),
        .pwr_mode(pwr_mode), .range_sel(range_sel), .coding_sel(coding_sel)
    );

    function automatic logic [15:0] mkw(logic wr, logic sq, logic [3:0] ad,
                                         logic [1:0] pw, logic sh, logic rg, logic cd);
        return {wr, sq, ad, pw, sh, 1'b1, rg, cd, 4'b1010};
    endfunction

    function automatic logic [3:0] m_next(logic [3:0] cur, logic [15:0] m);
        for (int i = 1; i <= 16; i++)
            if (m[(cur + i) % 16]) return 4'((cur + i) % 16);
        return cur;
    endfunction

    function automatic void model_reset();
        m_chan = 0; m_seq = 0; m_empty = 0; m_pend = 0;
        m_mask = 0; m_pwr = 0; m_rng = 0; m_cod = 0;
    endfunction

    function automatic void model_word(logic [15:0] w);
        logic [15:0] cm;
        if (m_pend) begin
            for (int i = 0; i < 16; i++) cm[i] = w[15-i];
            m_pend = 0; m_mask = cm; m_seq = 1; m_empty = (cm == 0);
            if (cm != 0) m_chan = m_next(4'd15, cm);
        end else if (!w[15]) begin
            if (m_seq) m_chan = m_next(m_chan, m_mask);
        end else begin
            m_pwr = w[9:8]; m_rng = w[5]; m_cod = w[4];
            case ({w[14], w[7]})
                2'b00: begin m_chan = w[13:10]; m_seq = 0; m_empty = 0; end
                2'b01: begin m_chan = w[13:10]; m_seq = 0; m_empty = 0; m_pend = 1; end
                2'b11: begin
                    for (int i = 0; i < 16; i++) m_mask[i] = (i <= w[13:10]);
                    m_chan = 0; m_seq = 1; m_empty = 0;
                end
                default: if (m_seq) m_chan = m_next(m_chan, m_mask);
            endcase
        end
    endfunction

    task automatic check_all(string tag);
        logic [9:0] act, exp;
        act = {chan_sel, seq_active, mask_empty, pwr_mode, range_sel, coding_sel};
        exp = {m_chan, m_seq, m_empty, m_pwr, m_rng, m_cod};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send_bits(logic [15:0] w, int nbits);
        @(negedge clk);
        fs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int b = 0; b < nbits; b++) begin
            sdi  = w[15-b];
            sclk = 1'b1;
            repeat (2) @(negedge clk);
            sclk = 1'b0;
            repeat (2) @(negedge clk);
        end
        fs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic frame(logic [15:0] w, string tag);
        send_bits(w, 16);
        model_word(w);
        check_all(tag);
    endtask

    task automatic partial(logic [15:0] w, int n);
        send_bits(w, n);
        check_all("R9 partial frame discarded");
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd17;
        void'($urandom(seed));
        model_reset();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check_all("R1 reset state");

        // Direct addressing
        frame(mkw(1, 0, 4'd5, 2'd1, 0, 1, 0), "R2 direct select");
        frame(mkw(0, 0, 4'd9, 2'd3, 0, 0, 1), "R3 write flag 0 keeps settings");
        // Range sequence 0..3 with wrap
        frame(mkw(1, 1, 4'd3, 2'd0, 1, 0, 1), "R6 range start at 0");
        frame(mkw(0, 1, 4'd0, 2'd0, 0, 0, 0), "R5 advance");
        frame(mkw(0, 1, 4'd0, 2'd0, 0, 0, 0), "R5 advance");
        frame(mkw(0, 1, 4'd0, 2'd0, 0, 0, 0), "R5 advance to top");
        frame(mkw(0, 1, 4'd0, 2'd0, 0, 0, 0), "R5 wrap to lowest");
        frame(mkw(1, 1, 4'd9, 2'd2, 0, 1, 1), "R7 keep code updates settings");
        frame(mkw(1, 0, 4'd12, 2'd0, 0, 0, 0), "R8 direct ends sequence");
        frame(mkw(1, 1, 4'd4, 2'd1, 0, 0, 0), "R7 keep code without sequence");
        // Arbitrary mask: channels 2, 9, 14
        frame(mkw(1, 0, 4'd7, 2'd0, 1, 0, 0), "R4 arm selects address");
        frame(16'h2042, "R4 mask load lowest channel");
        frame(mkw(0, 0, 4'd0, 2'd0, 0, 0, 0), "R5 sparse advance");
        frame(mkw(0, 0, 4'd0, 2'd0, 0, 0, 0), "R5 sparse advance");
        frame(mkw(0, 0, 4'd0, 2'd0, 0, 0, 0), "R5 sparse wrap");
        partial(16'hFFFF, 15);
        partial(16'h0000, 3);
        // Empty mask
        frame(mkw(1, 0, 4'd11, 2'd0, 1, 0, 0), "R4 arm");
        frame(16'h0000, "R10 empty mask holds channel");
        frame(mkw(0, 0, 4'd0, 2'd0, 0, 0, 0), "R10 empty mask no advance");
        frame(mkw(1, 1, 4'd6, 2'd0, 1, 0, 0), "R8 range code ends empty state");

        // Constrained random mix
        for (int n = 0; n < 300; n++) begin
            int unsigned k;
            logic [15:0] r;
            k = $urandom % 8;
            r = 16'($urandom);
            case (k)
                0, 1, 2: frame(r & 16'h7FFF, "R5 random no-write frame");
                3: frame(mkw(1, 0, r[13:10], r[9:8], 0, r[5], r[4]), "R2 random direct");
                4: begin
                    frame(mkw(1, 0, r[13:10], r[9:8], 1, r[5], r[4]), "R4 random arm");
                    frame((($urandom % 6) == 0) ? 16'h0000 : 16'($urandom),
                          "R4 R10 random mask load");
                end
                5: frame(mkw(1, 1, r[13:10], r[9:8], 1, r[5], r[4]), "R6 random range");
                6: frame(mkw(1, 1, r[13:10], r[9:8], 0, r[5], r[4]), "R7 random keep");
                default: partial(r, 1 + int'($urandom % 15));
            endcase
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule